// File: doc/BRIEF.md
# Output-Stationary Systolic 4x4 Matrix Multiplier

This block multiplies two 4x4 matrices of 8-bit unsigned operands, C = A·B. It uses a square grid of sixteen multiply-accumulate cells. Each product element stays in its own cell. The A operands travel rightward along the grid rows and the B operands travel downward along the grid columns. Each cell exchanges data only with its nearest neighbours, so no operand is broadcast across the array.

Software first loads both matrices through a single write port. It then pulses `start`. A sequencer feeds the edges of the grid with a diagonal skew. Row r of A is held back r cycles and column c of B is held back c cycles, so the two operands that belong together meet in the same cell on the same cycle. When the last product has been accumulated the block raises `done`. Any of the sixteen results can then be read combinationally by giving its row-major index.

Top module: `sysmat_top`

## Requirements
- R1: After `done`, `rd_data` for `rd_idx` = 4·r + c (r = row, c = column, both 0..3) equals the sum over k = 0..3 of A[r][k]·B[k][c].
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is stored into A if `wr_sel` = 0 and into B if `wr_sel` = 1, at row `wr_idx[3:2]` and column `wr_idx[1:0]`.
- R3: Results are correct for non-symmetric matrices. This covers A with every element distinct and B equal to the identity, for which C equals A.
- R4: `done` is low for the first 9 rising edges after the edge that samples `start`, and it is high after the 10th.
- R5: A `start` pulse clears every accumulator and drops `done` on the following cycle. Running the same matrices twice gives the same result rather than twice the result.
- R6: Skew slots that carry no data leave the accumulators unchanged. After `done`, the results and `done` stay fixed over further cycles, even when A is rewritten.
- R7: Accumulators are 18 bits wide and do not wrap: all operands equal to 255 gives 260100 in every element.
- R8: After synchronous reset `done` is 0 and every result reads 0.
- R9: A `start` pulse during a multiplication abandons it and starts a new one. `done` then follows R4 timing from the later pulse, and the results follow R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | Operand matrix select: 0 = A, 1 = B |
| wr_idx | input | 4 | Row-major element index of the write |
| wr_data | input | 8 | Unsigned operand value |
| start | input | 1 | One-cycle pulse: clear and begin multiplication |
| done | output | 1 | High while all sixteen results are final |
| rd_idx | input | 4 | Row-major index of the result to read |
| rd_data | output | 18 | Selected result element |

## Verification
The result of the latest `start` is due on the tenth rising edge after the edge that samples that pulse. The bench counts edges from that point. It samples `done` on the falling edge after the ninth edge, where it must still be low, and again after the tenth, where it must be high. Results are read only after `done` has been seen high. Because the read port is combinational, each index is applied on a falling edge and sampled a short delay later. For a restart, both the timing and the results are counted from the second pulse.

// File: rtl/sysmat_pkg.sv
package sysmat_pkg;
    localparam int N     = 4;
    localparam int OPW   = 8;
    localparam int ACCW  = 18;
    localparam int KW    = $clog2(N);
    localparam int IDXW  = $clog2(N * N);
    localparam int LAST  = 3 * N - 3;
    localparam int STEPW = $clog2(LAST + 1);

    typedef logic [OPW-1:0]   opnd_t;
    typedef logic [ACCW-1:0]  acc_t;
    typedef logic [STEPW-1:0] step_t;

    typedef struct packed {
        logic  vld;
        opnd_t val;
    } lane_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } seq_st_e;

    function automatic logic in_window(input int t, input int off);
        return (t >= off) && (t < off + N);
    endfunction
endpackage

// File: rtl/sysmat_ctrl.sv
module sysmat_ctrl
    import sysmat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  run,
    output step_t step,
    output logic  done
);
    seq_st_e state;
    step_t   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else if (state == ST_RUN) begin
            if (cnt == step_t'(LAST)) state <= ST_DONE;
            else                      cnt   <= cnt + 1'b1;
        end
    end

    assign run  = (state == ST_RUN);
    assign done = (state == ST_DONE);
    assign step = cnt;

    // R4: done may only appear right after the final feeding step
    p_done_latency_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(cnt) == step_t'(LAST)) && $past(run));

    // R5: a start pulse always withdraws done
    p_start_drops_done_r5: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    // R9: a start pulse always (re)enters the run phase at step zero
    p_restart_step0_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> run && (step == '0));
endmodule

// File: rtl/sysmat_pe.sv
module sysmat_pe
    import sysmat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  lane_t a_in,
    input  lane_t b_in,
    output lane_t a_out,
    output lane_t b_out,
    output acc_t  acc
);
    logic fire;
    assign fire = a_in.vld && b_in.vld;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            a_out <= '0;
            b_out <= '0;
            acc   <= '0;
        end else begin
            a_out <= a_in;
            b_out <= b_in;
            if (fire) acc <= acc + acc_t'(a_in.val) * acc_t'(b_in.val);
        end
    end

    // R6: an idle slot leaves the accumulator untouched
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!fire && !clr) |=> $stable(acc));

    // R7: accumulation never wraps
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && !clr) |=> acc >= $past(acc));

    // R5: clear empties the accumulator
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> acc == '0);
endmodule

// File: rtl/sysmat_top.sv
module sysmat_top
    import sysmat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [OPW-1:0]  wr_data,
    input  logic            start,
    output logic            done,
    input  logic [IDXW-1:0] rd_idx,
    output logic [ACCW-1:0] rd_data
);
    opnd_t a_mem [N][N];
    opnd_t b_mem [N][N];

    logic  run;
    step_t step;

    lane_t ah [N][N+1];
    lane_t bv [N+1][N];
    acc_t  cgrid [N][N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    a_mem[r][c] <= '0;
                    b_mem[r][c] <= '0;
                end
        end else if (wr_en) begin
            if (wr_sel) b_mem[wr_idx[IDXW-1:KW]][wr_idx[KW-1:0]] <= wr_data;
            else        a_mem[wr_idx[IDXW-1:KW]][wr_idx[KW-1:0]] <= wr_data;
        end
    end

    sysmat_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (run),
        .step  (step),
        .done  (done)
    );

    for (genvar e = 0; e < N; e++) begin : g_edge
        always_comb begin
            int k;
            logic [KW-1:0] kk;
            k  = int'(step) - e;
            kk = k[KW-1:0];
            ah[e][0].vld = run && in_window(int'(step), e);
            ah[e][0].val = ah[e][0].vld ? a_mem[e][kk] : '0;
            bv[0][e].vld = run && in_window(int'(step), e);
            bv[0][e].val = bv[0][e].vld ? b_mem[kk][e] : '0;
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            sysmat_pe u_pe (
                .clk   (clk),
                .rst   (rst),
                .clr   (start),
                .a_in  (ah[r][c]),
                .b_in  (bv[r][c]),
                .a_out (ah[r][c+1]),
                .b_out (bv[r+1][c]),
                .acc   (cgrid[r][c])
            );
        end
    end

    assign rd_data = cgrid[rd_idx[IDXW-1:KW]][rd_idx[KW-1:0]];

    // R6: once results have settled no operand leaves the grid edges
    for (genvar e = 0; e < N; e++) begin : g_drain
        p_drained_r6: assert property (@(posedge clk) disable iff (rst)
            (done && $past(done)) |-> (ah[e][N] == '0) && (bv[N][e] == '0));
    end

    // R6: results are frozen while done holds
    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(cgrid[N-1][N-1]) && $stable(cgrid[0][0]));
endmodule

// File: tb/sysmat_top_bench.sv
`timescale 1ns/1ps
module sysmat_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        start = 1'b0;
    logic        done;
    logic [3:0]  rd_idx = '0;
    logic [17:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    int ma [4][4];
    int mb [4][4];

    localparam int unsigned SEEDS [5] = '{1, 17, 90, 201, 254};

    always #4 clk = ~clk;

    sysmat_top u_sysmat_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .start(start), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_mats();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                wr_en   = 1'b1;
                wr_sel  = s[0];
                wr_idx  = i[3:0];
                wr_data = (s == 0) ? ma[i/4][i%4][7:0] : mb[i/4][i%4][7:0];
            end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_done_timing(input string req);
        repeat (9) @(posedge clk);
        @(negedge clk);
        chk(req, int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        chk(req, int'(done), 1);
    endtask

    task automatic check_results(input string req);
        for (int i = 0; i < 16; i++) begin
            int exp;
            exp = 0;
            for (int k = 0; k < 4; k++) exp += ma[i/4][k] * mb[k][i%4];
            @(negedge clk);
            rd_idx = i[3:0];
            #1;
            chk(req, int'(rd_data), exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        chk("R8 done", int'(done), 0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx = i[3:0];
            #1;
            chk("R8 result", int'(rd_data), 0);
        end

        // R1 R2 R4: table of seeded matrix pairs
        foreach (SEEDS[v]) begin
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++) begin
                    ma[i][j] = int'((SEEDS[v] * (4*i + j + 1) + 3*i) & 255);
                    mb[i][j] = int'((SEEDS[v] + 29*(4*i + j) + 5*j*j) & 255);
                end
            load_mats();
            pulse_start();
            check_done_timing("R4 table");
            check_results("R1 R2 table");
        end

        // R5: rerun without reload must not double
        pulse_start();
        chk("R5 done drop", int'(done), 0);
        check_done_timing("R5 rerun");
        check_results("R5 rerun");

        // R3: distinct A times identity gives A
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                ma[i][j] = 11 * (4*i + j) + 7;
                mb[i][j] = (i == j) ? 1 : 0;
            end
        load_mats();
        pulse_start();
        check_done_timing("R3 identity");
        check_results("R3 identity");

        // R3: transposed pattern, non-symmetric
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                ma[i][j] = (i == 0) ? 200 : i + j;
                mb[i][j] = (j == 3) ? 100 + i : 2 * i + 1;
            end
        load_mats();
        pulse_start();
        check_done_timing("R3 skew");
        check_results("R3 skew");

        // R7: full-scale operands
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                ma[i][j] = 255;
                mb[i][j] = 255;
            end
        load_mats();
        pulse_start();
        check_done_timing("R7 max");
        check_results("R7 max");

        // R6: rewriting A after done changes nothing
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 1'b0; wr_idx = i[3:0]; wr_data = 8'd3;
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (6) @(negedge clk);
        chk("R6 done held", int'(done), 1);
        check_results("R6 idle");
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) ma[i][j] = 3;

        // R9: restart mid-run
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                ma[i][j] = 5 * i + j + 1;
                mb[i][j] = 40 - 3 * j - i;
            end
        load_mats();
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R9 mid-run", int'(done), 0);
        pulse_start();
        check_done_timing("R9 restart");
        check_results("R9 restart");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule